// File: doc/BRIEF.md
# Phase-Shift Pulse Width Digitizer

This block measures the phase angle between a line-voltage square wave and a current square wave. The current wave reaches it already shifted by a quarter period. The block forms a window that is high while the voltage wave is high and the current wave is low. A fully lagging load therefore gives an empty window, and the window widens linearly as the load moves toward leading.

During the window the block counts ticks of a fast chopper enable. When the window closes, the count is copied into an output register, a one-cycle strobe is raised and the counter restarts from zero. This gives one binary phase reading per line cycle. A decision stage downstream compares each reading with two threshold counts to choose a capacitor bank setting.

The chopper rate should stay at or below 2·f_line·(2^n − 1) for an n-bit counter, so that a half-period window stays just under full scale. The output is a plain valid strobe with no ready input. A phase measurement cannot be paused, so the reading simply holds until the next window closes, and the consumer takes it on the strobe.

Top module: `phase_width_digitizer`

## Requirements
- R1: While reset is asserted and after its release, before any window has closed, `phase_count` is 0 and `phase_valid` is 0.
- R2: The window is open only in cycles where the synchronized voltage input is 1 and the synchronized current input is 0. Every other input combination adds no count and closes no window.
- R3: In each cycle of an open window where `chop_tick` is 1, the running count rises by one. A cycle with `chop_tick` at 0 leaves the count unchanged.
- R4: When the window closes, `phase_count` takes the number of ticks counted in that window, and the next window starts counting from 0.
- R5: `phase_valid` is high for exactly one cycle per closed window, in the same cycle `phase_count` first shows the new reading. `phase_count` does not change in any other cycle.
- R6: The running count saturates at 2^CNT_W − 1 and does not wrap. An overlong window reads as all ones.
- R7: Each square-wave input passes through two flops. If the window input pattern ends in clock cycle t, `phase_valid` is seen in cycle t+3.
- R8: A line cycle with an empty window (fully lagging load) produces no strobe, and the previous reading is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chop_tick | input | 1 | Chopper-rate enable, one clock cycle per tick |
| volt_sq | input | 1 | Line-voltage square wave, asynchronous |
| curr_sq | input | 1 | Quarter-period-shifted current square wave, asynchronous |
| phase_count | output | CNT_W | Latched tick count of the last closed window |
| phase_valid | output | 1 | One-cycle strobe marking a new reading |

## Verification
The properties assume that reset is held low across the first clock edge and that `chop_tick` is meaningful on every cycle, with no minimum spacing. They place no demand on when the square waves switch, because the two-flop stages absorb any alignment. The stimulus changes all inputs only on the falling clock edge. It sweeps the window width from empty to past full scale under several tick spacings, and it includes stretches where both waves are high or both are low. Every reading therefore comes from a legal window, and the saturation and empty-window cases are both reached.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // default running-count width
  parameter int unsigned PWD_CNT_W  = 8;
  // flops in each square-wave resynchronizer
  parameter int unsigned PWD_STAGES = 2;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= '0;
          else        chain[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= '0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwd_window.sv
module pwd_window (
  input  logic clk,
  input  logic rst_n,
  input  logic v_s,
  input  logic c_s,
  output logic win,
  output logic win_close
);
  logic win_q;

  // digital subtract-then-rectify: voltage high, current low
  assign win = v_s & ~c_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win;

  assign win_close = win_q & ~win;
endmodule

// File: rtl/pwd_accum.sv
module pwd_accum #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             win,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              cnt <= '0;
    else if (clear)                          cnt <= '0;
    else if (win && tick && (cnt != FULL))   cnt <= cnt + 1'b1;
endmodule

// File: rtl/phase_width_digitizer.sv
module phase_width_digitizer
  import pwd_pkg::*;
#(
  parameter int unsigned CNT_W  = PWD_CNT_W,
  parameter int unsigned STAGES = PWD_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chop_tick,
  input  logic             volt_sq,
  input  logic             curr_sq,
  output logic [CNT_W-1:0] phase_count,
  output logic             phase_valid
);
  logic [1:0]       sq_s;
  logic             win_now;
  logic             win_close;
  logic [CNT_W-1:0] run_cnt;

  pwd_sync #(.WIDTH(2), .STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({volt_sq, curr_sq}), .q(sq_s)
  );

  pwd_window i_window (
    .clk(clk), .rst_n(rst_n), .v_s(sq_s[1]), .c_s(sq_s[0]),
    .win(win_now), .win_close(win_close)
  );

  pwd_accum #(.CNT_W(CNT_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .tick(chop_tick), .win(win_now),
    .clear(win_close), .cnt(run_cnt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_count <= '0;
      phase_valid <= 1'b0;
    end else begin
      phase_valid <= win_close;
      if (win_close) phase_count <= run_cnt;
    end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chop_tick,
  input logic             win,
  input logic             win_close,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] phase_count,
  input logic             phase_valid
);
  localparam logic [CNT_W-1:0] FULL = '1;

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |=> !phase_valid);

  // R5
  strobe_follows_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> phase_valid);

  // R5
  reading_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid |-> $stable(phase_count));

  // R4
  reading_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> (phase_count == $past(cnt)));

  // R4
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |-> (cnt == '0));

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win && chop_tick && cnt != FULL) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !chop_tick) |=> $stable(cnt));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !win_close) |=> (cnt == FULL));
endmodule

bind phase_width_digitizer pwd_checker #(.CNT_W(CNT_W)) i_pwd_checker (
  .clk(clk), .rst_n(rst_n), .chop_tick(chop_tick), .win(win_now),
  .win_close(win_close), .cnt(run_cnt), .phase_count(phase_count),
  .phase_valid(phase_valid)
);

// File: tb/test_phase_width_digitizer.sv
`timescale 1ns/1ps
module test_phase_width_digitizer;
  localparam int unsigned W    = 4;
  localparam int unsigned HALF = 20;
  localparam logic [W-1:0] FULL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chop_tick = 1'b0, volt_sq = 1'b0, curr_sq = 1'b0;
  logic [W-1:0] phase_count;
  logic phase_valid;

  int total = 0, bad = 0;
  int cyc = 0;
  logic pb1 = 0, pb2 = 0, pb3 = 0;
  logic [W-1:0] acc = '0, exp_data = '0;
  logic exp_valid = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  phase_width_digitizer #(.CNT_W(W)) i_phase_width_digitizer (
    .clk(clk), .rst_n(rst_n), .chop_tick(chop_tick), .volt_sq(volt_sq),
    .curr_sq(curr_sq), .phase_count(phase_count), .phase_valid(phase_valid)
  );

  task automatic step(input logic v, input logic c, input logic tk, input string tag);
    logic closes;
    @(negedge clk);
    total++;
    if (phase_valid !== exp_valid) begin
      bad++;
      $display("FAIL %s R5 R7 strobe cyc=%0d got=%0b exp=%0b", tag, cyc, phase_valid, exp_valid);
    end
    total++;
    if (phase_count !== exp_data) begin
      bad++;
      $display("FAIL %s %s reading cyc=%0d got=%0d exp=%0d", tag,
               (exp_data == FULL) ? "R6" : "R4", cyc, phase_count, exp_data);
    end
    volt_sq = v; curr_sq = c; chop_tick = tk;
    closes = pb3 & ~pb2;
    if (closes) begin
      exp_valid = 1'b1; exp_data = acc; acc = '0;
    end else begin
      exp_valid = 1'b0;
      if (pb2 && tk && acc != FULL) acc = acc + 1'b1;
    end
    pb3 = pb2; pb2 = pb1; pb1 = v & ~c;
    cyc++;
  endtask

  task automatic line_cycle(input int s, input int d, input string tag);
    for (int k = 0; k < 2*HALF; k++) begin
      logic v, c, tk;
      v  = (k < HALF);
      c  = ((k - s + 2*HALF) % (2*HALF)) < HALF;
      tk = (d == 0) ? 1'b0 : ((cyc % d) == 0);
      step(v, c, tk, tag);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (phase_count !== '0 || phase_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset got=%0d/%0b exp=0/0", phase_count, phase_valid);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R1");
    // R2: non-window combinations with ticks running
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1, "R2");
    // R3 R6 R8: width sweep under several tick spacings
    for (int d = 0; d <= 3; d++)
      for (int s = 0; s <= HALF; s++)
        line_cycle(s, d, (s == 0) ? "R8" : ((s > int'(FULL)) ? "R6" : "R3"));
    // R7: single short window then quiet
    step(1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, "R7");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule